// File: doc/BRIEF.md
# Packet Network Interface Control and Status Register

This block is the command and status register of a packet network adapter that sits on a 36-bit processor I/O bus. A single control write does two jobs. It fires one-shot commands (start a transmission, flush the transmitter, clear receive-done, or a full interface reset), and it then loads the mode and error fields from the written value. A status read returns those fields together with the two done flags and the station's node address. From the done flags and their enables the block derives an interrupt request on a software-chosen 3-bit priority channel.

The block also decides whether an arriving packet is taken. A packet is taken when it is addressed to this station, when it is a broadcast to address zero, or when monitor-all mode is on. While an earlier packet is still waiting to be read, a newly taken packet is discarded and counted in a saturating 4-bit drop counter inside the status word. The packet buffers and the checksum logic live elsewhere. This block only sees their event strobes and hands them command pulses.

Top module: `nic_csr`

## Requirements
- R1: After the asynchronous reset, the low 20 status bits read 0x00200 (only transmit-done, bit 9, is set). The interrupt request is low and the receive-enable output is high.
- R2: A control write loads bits 8:0, bit 11 (transmit abort), bits 15:12 (drop count) and bits 19:16 (checksum, word-length, packet-length and overrun errors) from the written value. This load happens after the write's commands. The done bits 9 and 10 are never loaded.
- R3: The interrupt request is high exactly when (receive-done, bit 10, and receive enable, bit 4, are both set) or (transmit-done, bit 9, and transmit enable, bit 3, are both set). The channel output equals status bits 2:0.
- R4: A write with bit 9 set and bit 12 clear gives a one-cycle transmit-start pulse in the cycle after the write, and leaves transmit-done unchanged. A write with bit 11 set gives a one-cycle flush pulse and sets transmit-done.
- R5: A write with bit 12 set performs a full reset before the field load. It clears receive-done, sets transmit-done, pulses flush, and suppresses any transmit start in the same write.
- R6: A write with bit 10 set clears receive-done, which raises the receive-enable output again.
- R7: An arriving packet is taken only if its destination equals the node address, is zero, or monitor-all (bit 5) is set. A taken packet arriving while receive-done is clear sets receive-done and gives a one-cycle take pulse. A packet that is not taken changes nothing.
- R8: A taken packet arriving while receive-done is set is dropped with no take pulse. The drop count in bits 15:12 goes up by one and holds at 15.
- R9: The status word carries the node address in bits 35:20.
- R10: The error strobes set checksum error (bit 16), word-length error (bit 17), packet-length error (bit 18), overrun (bit 19) and transmit abort (bit 11). Each bit stays set until a control write loads it.
- R11: A transmit-data load strobe clears transmit-done. A transmitter-idle strobe sets it, and wins when both occur in the same cycle.
- R12: The loopback, byte-swap and half-word outputs follow status bits 6, 7 and 8.

Events in the same cycle as a control write take effect on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_data_i | input | 20 | Control write value |
| tx_load_i | input | 1 | Transmit data word loaded |
| tx_idle_i | input | 1 | Transmitter has no pending data |
| tx_abort_i | input | 1 | Transmission aborted |
| crc_err_i | input | 1 | Checksum error strobe |
| wlen_err_i | input | 1 | Word-length error strobe |
| plen_err_i | input | 1 | Packet-length error strobe |
| overrun_i | input | 1 | Overrun strobe |
| pkt_valid_i | input | 1 | Packet arrival strobe |
| pkt_dest_i | input | 16 | Destination of arriving packet |
| node_addr_i | input | 16 | This station's node address |
| status_o | output | 36 | Status read word |
| irq_o | output | 1 | Interrupt request |
| irq_chan_o | output | 3 | Interrupt priority channel |
| tx_start_o | output | 1 | Start-transmission pulse |
| tx_flush_o | output | 1 | Flush transmit buffer pulse |
| pkt_take_o | output | 1 | Packet accepted pulse |
| rx_enable_o | output | 1 | Reception armed |
| loopback_o | output | 1 | Loopback mode |
| swap_o | output | 1 | Byte swap mode |
| half_o | output | 1 | Half-word mode |

## Verification
The hardest state to reach is a saturated drop counter. It needs one packet held in receive-done followed by at least fifteen more taken packets, with no control write in between, because a write would reload the counter. The bench parks a packet to this node, then streams further packets to it. Along the way it sends a mismatched destination to confirm that such a packet leaves the count unchanged, and it finishes with a full-reset write carrying transmit start, to check that the reset command has priority.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  // Bit positions are decoded by software and by the interrupt logic.
  localparam int CTL_W     = 20;
  localparam int LOST_W    = 4;
  localparam int B_TXIE    = 3;
  localparam int B_RXIE    = 4;
  localparam int B_SPY     = 5;
  localparam int B_LOOP    = 6;
  localparam int B_SWAP    = 7;
  localparam int B_HALF    = 8;
  localparam int B_TXDONE  = 9;
  localparam int B_RXDONE  = 10;
  localparam int B_ABORT   = 11;
  localparam int B_LOST    = 12;
  localparam int B_ERR     = 16;
  localparam int N_ERR     = 4;
  localparam logic [CTL_W-1:0] LOAD_MASK = 20'hFF9FF;

  typedef struct packed {
    logic rst;
    logic clr_rx;
    logic clr_tx;
    logic xmit;
  } nic_cmd_t;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_csr_pkg::*;
(
  input  logic             wr_i,
  input  logic [CTL_W-1:0] data_i,
  output nic_cmd_t         cmd_o
);
  always_comb begin
    cmd_o.rst    = wr_i & data_i[B_LOST];
    cmd_o.clr_rx = wr_i & data_i[B_RXDONE];
    cmd_o.clr_tx = wr_i & data_i[B_ABORT];
    // full reset takes priority over a transmit start in the same write
    cmd_o.xmit   = wr_i & data_i[B_TXDONE] & ~data_i[B_LOST];
  end
endmodule

// File: rtl/nic_rx_filter.sv
module nic_rx_filter #(
  parameter int ADDR_W = 16
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] dest_i,
  input  logic [ADDR_W-1:0] node_i,
  input  logic              spy_i,
  output logic              match_o
);
  logic to_us, to_all;
  always_comb begin
    to_us   = (dest_i == node_i);
    to_all  = (dest_i == '0);
    match_o = valid_i & (to_us | to_all | spy_i);
  end
endmodule

// File: rtl/nic_irq.sv
module nic_irq #(
  parameter int CHAN_W = 3
) (
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              irq_o,
  output logic [CHAN_W-1:0] chan_o
);
  always_comb begin
    irq_o  = (rx_done_i & rx_en_i) | (tx_done_i & tx_en_i);
    chan_o = chan_i;
  end
endmodule

// File: rtl/nic_csr.sv
module nic_csr
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 36,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_data_i,
  input  logic              tx_load_i,
  input  logic              tx_idle_i,
  input  logic              tx_abort_i,
  input  logic              crc_err_i,
  input  logic              wlen_err_i,
  input  logic              plen_err_i,
  input  logic              overrun_i,
  input  logic              pkt_valid_i,
  input  logic [ADDR_W-1:0] pkt_dest_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o,
  output logic [CHAN_W-1:0] irq_chan_o,
  output logic              tx_start_o,
  output logic              tx_flush_o,
  output logic              pkt_take_o,
  output logic              rx_enable_o,
  output logic              loopback_o,
  output logic              swap_o,
  output logic              half_o
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;
  localparam logic [CTL_W-1:0]  RST_VAL  = CTL_W'(1) << B_TXDONE;

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             start_q, start_d;
  logic             flush_q, flush_d;
  logic             take_q, take_d;
  logic             pkt_match;
  logic [N_ERR-1:0] err_vec;
  logic [LOST_W-1:0] lost_n;
  nic_cmd_t         cmd;

  nic_cmd_decode u_dec (
    .wr_i   (ctl_wr_i),
    .data_i (ctl_data_i),
    .cmd_o  (cmd)
  );

  nic_rx_filter #(.ADDR_W(ADDR_W)) u_filt (
    .valid_i (pkt_valid_i),
    .dest_i  (pkt_dest_i),
    .node_i  (node_addr_i),
    .spy_i   (ctl_q[B_SPY]),
    .match_o (pkt_match)
  );

  nic_irq #(.CHAN_W(CHAN_W)) u_irq (
    .tx_done_i (ctl_q[B_TXDONE]),
    .rx_done_i (ctl_q[B_RXDONE]),
    .tx_en_i   (ctl_q[B_TXIE]),
    .rx_en_i   (ctl_q[B_RXIE]),
    .chan_i    (ctl_q[CHAN_W-1:0]),
    .irq_o     (irq_o),
    .chan_o    (irq_chan_o)
  );

  assign err_vec = {overrun_i, plen_err_i, wlen_err_i, crc_err_i};

  // next-state: commands, then field load, then hardware events
  always_comb begin
    ctl_d   = ctl_q;
    start_d = cmd.xmit;
    flush_d = cmd.clr_tx | cmd.rst;
    take_d  = 1'b0;
    lost_n  = '0;

    if (cmd.rst)    ctl_d = RST_VAL;
    if (cmd.clr_rx) ctl_d[B_RXDONE] = 1'b0;
    if (cmd.clr_tx) ctl_d[B_TXDONE] = 1'b1;
    if (ctl_wr_i)   ctl_d = (ctl_d & ~LOAD_MASK) | (ctl_data_i & LOAD_MASK);

    if (tx_load_i)  ctl_d[B_TXDONE] = 1'b0;
    if (tx_idle_i)  ctl_d[B_TXDONE] = 1'b1;
    if (tx_abort_i) ctl_d[B_ABORT]  = 1'b1;

    for (int i = 0; i < N_ERR; i++) begin
      if (err_vec[i]) ctl_d[B_ERR+i] = 1'b1;
    end

    if (pkt_match) begin
      if (!ctl_d[B_RXDONE]) begin
        ctl_d[B_RXDONE] = 1'b1;
        take_d          = 1'b1;
      end else begin
        lost_n = ctl_d[B_LOST +: LOST_W];
        if (lost_n != LOST_MAX) ctl_d[B_LOST +: LOST_W] = lost_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= RST_VAL;
      start_q <= 1'b0;
      flush_q <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      start_q <= start_d;
      flush_q <= flush_d;
      take_q  <= take_d;
    end
  end

  always_comb begin
    status_o                   = '0;
    status_o[CTL_W-1:0]        = ctl_q;
    status_o[CTL_W +: ADDR_W]  = node_addr_i;
  end

  assign tx_start_o  = start_q;
  assign tx_flush_o  = flush_q;
  assign pkt_take_o  = take_q;
  assign rx_enable_o = ~ctl_q[B_RXDONE];
  assign loopback_o  = ctl_q[B_LOOP];
  assign swap_o      = ctl_q[B_SWAP];
  assign half_o      = ctl_q[B_HALF];
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr_i,
  input logic              wd_xmit,
  input logic              wd_clr_rx,
  input logic              wd_rst,
  input logic              tx_load_i,
  input logic              pkt_valid_i,
  input logic [ADDR_W-1:0] pkt_dest_i,
  input logic [ADDR_W-1:0] node_addr_i,
  input logic              spy,
  input logic              tx_done,
  input logic              rx_done,
  input logic              txie,
  input logic              rxie,
  input logic [3:0]        lost,
  input logic              irq_o,
  input logic              tx_start_o
);
  logic taken;
  assign taken = pkt_valid_i &&
                 (pkt_dest_i == node_addr_i || pkt_dest_i == '0 || spy);

  // R3
  a_r3_irq_rule: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((rx_done && rxie) || (tx_done && txie)));

  // R4
  a_r4_start_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i && wd_xmit && !wd_rst |=> tx_start_o);

  // R5
  a_r5_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i && wd_rst && !tx_load_i && !pkt_valid_i |=> !tx_start_o && tx_done && !rx_done);

  // R6
  a_r6_rx_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !(ctl_wr_i && (wd_clr_rx || wd_rst)) |=> rx_done);

  // R8
  a_r8_lost_counts: assert property (@(posedge clk) disable iff (!rst_n)
    taken && rx_done && !ctl_wr_i && lost != 4'hF |=> lost == $past(lost) + 4'd1);

  // R8
  a_r8_lost_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    lost == 4'hF && !ctl_wr_i |=> lost == 4'hF);
endmodule

bind nic_csr nic_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr_i    (ctl_wr_i),
  .wd_xmit     (ctl_data_i[9]),
  .wd_clr_rx   (ctl_data_i[10]),
  .wd_rst      (ctl_data_i[12]),
  .tx_load_i   (tx_load_i),
  .pkt_valid_i (pkt_valid_i),
  .pkt_dest_i  (pkt_dest_i),
  .node_addr_i (node_addr_i),
  .spy         (status_o[5]),
  .tx_done     (status_o[9]),
  .rx_done     (status_o[10]),
  .txie        (status_o[3]),
  .rxie        (status_o[4]),
  .lost        (status_o[15:12]),
  .irq_o       (irq_o),
  .tx_start_o  (tx_start_o)
);

// File: tb/tb_nic_csr.sv
module tb_nic_csr;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] NODE = 16'h0A5C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr;
  logic [19:0] ctl_data;
  logic        tx_load, tx_idle, tx_abort, crc_err, wlen_err, plen_err, overrun;
  logic        pkt_valid;
  logic [15:0] pkt_dest, node_addr;
  logic [35:0] status;
  logic        irq, tx_start, tx_flush, pkt_take, rx_enable, loopback, swap, half;
  logic [2:0]  irq_chan;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_csr dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_data_i(ctl_data),
    .tx_load_i(tx_load), .tx_idle_i(tx_idle), .tx_abort_i(tx_abort),
    .crc_err_i(crc_err), .wlen_err_i(wlen_err), .plen_err_i(plen_err),
    .overrun_i(overrun), .pkt_valid_i(pkt_valid), .pkt_dest_i(pkt_dest),
    .node_addr_i(node_addr), .status_o(status), .irq_o(irq),
    .irq_chan_o(irq_chan), .tx_start_o(tx_start), .tx_flush_o(tx_flush),
    .pkt_take_o(pkt_take), .rx_enable_o(rx_enable), .loopback_o(loopback),
    .swap_o(swap), .half_o(half)
  );

  task automatic chk(input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ctl_write(input logic [19:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_data = '0;
  endtask

  // bit0 load, 1 idle, 2 abort, 3 crc, 4 wlen, 5 plen, 6 overrun
  task automatic ev(input logic [6:0] m);
    @(negedge clk);
    {overrun, plen_err, wlen_err, crc_err, tx_abort, tx_idle, tx_load} = m;
    @(negedge clk);
    {overrun, plen_err, wlen_err, crc_err, tx_abort, tx_idle, tx_load} = '0;
  endtask

  task automatic pkt(input logic [15:0] dest);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_dest = dest;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_dest = '0;
  endtask

  task automatic t_reset();
    hw_reset();
    chk("R1", "status", status, {NODE, 20'h00200});
    chk("R1", "irq", 36'(irq), 36'd0);
    chk("R1", "rx_enable", 36'(rx_enable), 36'd1);
  endtask

  task automatic t_modes();
    hw_reset();
    ctl_write(20'h501C5);
    chk("R2", "load fields", 36'(status[19:0]), 36'h503C5);
    chk("R12", "mode outs", 36'({loopback, swap, half}), 36'b111);
    chk("R3", "irq chan", 36'(irq_chan), 36'd5);
    chk("R3", "irq off", 36'(irq), 36'd0);
    ctl_write(20'h0A000);
    chk("R2", "lost load", 36'(status[19:0]), 36'h0A200);
    chk("R12", "loopback off", 36'(loopback), 36'd0);
  endtask

  task automatic t_irq();
    hw_reset();
    ctl_write(20'h00008);
    chk("R3", "tx irq", 36'({irq, status[19:0]}), {16'd0, 1'b1, 20'h00208});
    ev(7'b0000001);
    chk("R11", "load clears done", 36'({irq, status[19:0]}), {16'd0, 1'b0, 20'h00008});
    ev(7'b0000011);
    chk("R11", "idle wins", 36'({irq, status[19:0]}), {16'd0, 1'b1, 20'h00208});
    ctl_write(20'h00010);
    chk("R3", "rx en only", 36'({irq, status[19:0]}), {16'd0, 1'b0, 20'h00210});
    pkt(NODE);
    chk("R3", "rx irq", 36'({irq, status[19:0]}), {16'd0, 1'b1, 20'h00610});
  endtask

  task automatic t_filter();
    hw_reset();
    pkt(16'h1234);
    chk("R7", "mismatch ignored", 36'({pkt_take, status[19:0]}), {16'd0, 1'b0, 20'h00200});
    pkt(NODE);
    chk("R7", "own node", 36'({pkt_take, status[19:0]}), {16'd0, 1'b1, 20'h00600});
    chk("R7", "rx disarmed", 36'(rx_enable), 36'd0);
    ctl_write(20'h00400);
    chk("R6", "clear rx", 36'({rx_enable, status[19:0]}), {16'd0, 1'b1, 20'h00200});
    pkt(16'h0000);
    chk("R7", "broadcast", 36'({pkt_take, status[19:0]}), {16'd0, 1'b1, 20'h00600});
    ctl_write(20'h00420);
    chk("R6", "clear plus spy", 36'(status[19:0]), 36'h00220);
    pkt(16'h1234);
    chk("R7", "spy takes any", 36'({pkt_take, status[19:0]}), {16'd0, 1'b1, 20'h00620});
  endtask

  task automatic t_lost();
    hw_reset();
    pkt(NODE);
    pkt(NODE);
    chk("R8", "first drop", 36'({pkt_take, status[19:0]}), {16'd0, 1'b0, 20'h01600});
    pkt(16'h4321);
    chk("R8", "mismatch no count", 36'(status[19:0]), 36'h01600);
    for (int i = 0; i < 16; i++) pkt(NODE);
    chk("R8", "saturated", 36'(status[19:0]), 36'h0F600);
  endtask

  task automatic t_cmds();
    hw_reset();
    ctl_write(20'h00200);
    chk("R4", "start pulse", 36'({tx_start, status[19:0]}), {16'd0, 1'b1, 20'h00200});
    @(negedge clk);
    chk("R4", "start one cycle", 36'(tx_start), 36'd0);
    ev(7'b0000001);
    ctl_write(20'h00800);
    chk("R4", "flush", 36'({tx_flush, status[19:0]}), {16'd0, 1'b1, 20'h00A00});
    ctl_write(20'h00000);
    pkt(NODE);
    chk("R5", "pre reset", 36'(status[19:0]), 36'h00600);
    ctl_write(20'h01208);
    chk("R5", "reset result", 36'(status[19:0]), 36'h01208);
    chk("R5", "no start", 36'({tx_start, tx_flush}), 36'b01);
  endtask

  task automatic t_errors();
    hw_reset();
    ev(7'b1001100);
    chk("R10", "set errs", 36'(status[19:0]), 36'h90A00);
    @(negedge clk);
    chk("R10", "errs hold", 36'(status[19:0]), 36'h90A00);
    ctl_write(20'h00000);
    chk("R10", "write clears", 36'(status[19:0]), 36'h00200);
    ev(7'b0110000);
    chk("R10", "wlen plen", 36'(status[19:0]), 36'h60200);
  endtask

  task automatic t_node();
    node_addr = 16'hFFFF;
    @(negedge clk);
    chk("R9", "node field", 36'(status[35:20]), 36'hFFFF);
    node_addr = 16'h0001;
    @(negedge clk);
    chk("R9", "node field", 36'(status[35:20]), 36'h0001);
    node_addr = NODE;
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_data = '0;
    {overrun, plen_err, wlen_err, crc_err, tx_abort, tx_idle, tx_load} = '0;
    pkt_valid = 1'b0; pkt_dest = '0; node_addr = NODE;
    t_reset();
    t_modes();
    t_irq();
    t_filter();
    t_lost();
    t_cmds();
    t_errors();
    t_node();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule